// File: doc/BRIEF.md
# Serial Memory Power-State Sequencer

This block tracks the power state of a serial memory and tells the rest of the memory whether a command may run. After a power-up reset it holds a lockout for a start-up time. It then allows access until a sleep command is confirmed by a chip-select rise. At that point it turns the regulators off and times an entry interval before it reports that the low-current state has been reached.

A wake command, also confirmed by a chip-select rise, turns the regulators back on. Access stays blocked for an exit interval, and chip select must stay idle for that whole interval. If chip select is asserted during the exit interval, a sticky violation flag is raised and stays set until the next power-up reset.

The command strobes come from an upstream decoder. Each interval is a parameter in clock cycles, and by default it is derived from a clock rate in MHz and a time in microseconds.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it, `access_ok_o`=0, `reg_en_o`=1, `asleep_o`=0 and `cs_viol_o`=0. A reset also clears a set violation flag.
- R2: `access_ok_o` stays 0 through the first PU_CYC-1 rising clock edges after reset release, and it reads 1 after edge PU_CYC.
- R3: In the active state, a `sleep_cmd_i` strobe followed by a `cs_rise_i` pulse drives `access_ok_o` and `reg_en_o` to 0 right after the edge that samples `cs_rise_i`.
- R4: `asleep_o` is 0 for DP_CYC-1 edges after the edge that accepted sleep, and it is 1 after edge DP_CYC. The regulators stay off.
- R5: In the entry or sleep state, a `wake_cmd_i` strobe followed by a `cs_rise_i` pulse sets `reg_en_o`=1 and `asleep_o`=0 right after the accepting edge. `access_ok_o` is 0 for RDP_CYC-1 further edges and is 1 after edge RDP_CYC.
- R6: A command strobe has no effect until a `cs_rise_i` pulse follows it. A `cs_rise_i` pulse with no armed command has no effect.
- R7: The following are ignored: sleep while asleep, wake while active, and any command during the power-up lockout.
- R8: If `cs_low_i` is 1 in any cycle of the exit interval, `cs_viol_o` becomes 1 and stays 1 until reset. The exit interval still completes on time.
- R9: `cs_low_i` outside the exit interval never sets `cs_viol_o`.
- R10: A wake accepted during the entry interval abandons the entry. `asleep_o` never rises, and the exit interval starts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| sleep_cmd_i | input | 1 | Decoded sleep command strobe |
| wake_cmd_i | input | 1 | Decoded wake command strobe |
| cs_rise_i | input | 1 | One-cycle pulse when chip select is released |
| cs_low_i | input | 1 | Chip select asserted level |
| access_ok_o | output | 1 | Command execution allowed |
| reg_en_o | output | 1 | Regulator enable |
| asleep_o | output | 1 | Low-current state reached |
| cs_viol_o | output | 1 | Chip select was asserted during the exit interval |

## Verification
Each interval is measured by sampling the outputs on the edge before its expected end and on the edge at its end. This separates an exact count from one that is off by one cycle.

Command strobes are tried in four ways: alone, with a chip-select rise, in the wrong state, and during the lockout. These patterns separate the arming logic from the confirming logic. A wake that lands mid-entry exercises the abort path.

Chip select is driven low in sleep, in the active state and inside the exit interval. Only the last of these may raise the violation flag.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_ENTER  = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_EXIT   = 3'd4
  } pwr_state_e;

  localparam int unsigned CMD_SLEEP = 0;
  localparam int unsigned CMD_WAKE  = 1;
  localparam int unsigned NUM_CMD   = 2;
endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned INIT_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(INIT_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_cmd_arm.sv
// Holds a decoded command until chip select is released.
module pwr_cmd_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_en_i,
  input  logic cmd_i,
  input  logic cs_rise_i,
  output logic go_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_q <= 1'b0;
    else if (cs_rise_i)           pend_q <= 1'b0;
    else if (arm_en_i && cmd_i)   pend_q <= 1'b1;
  end

  assign go_o = cs_rise_i && arm_en_i && (pend_q || cmd_i);
endmodule

// File: rtl/pwr_viol_trap.sv
module pwr_viol_trap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic window_i,
  input  logic cs_low_i,
  output logic viol_o
);
  logic viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    viol_q <= 1'b0;
    else if (window_i && cs_low_i)  viol_q <= 1'b1;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned PU_US   = 400,
  parameter int unsigned DP_US   = 3,
  parameter int unsigned RDP_US  = 400,
  parameter int unsigned PU_CYC  = CLK_MHZ * PU_US,
  parameter int unsigned DP_CYC  = CLK_MHZ * DP_US,
  parameter int unsigned RDP_CYC = CLK_MHZ * RDP_US
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_cmd_i,
  input  logic wake_cmd_i,
  input  logic cs_rise_i,
  input  logic cs_low_i,
  output logic access_ok_o,
  output logic reg_en_o,
  output logic asleep_o,
  output logic cs_viol_o
);
  localparam int unsigned MAX_A   = (PU_CYC > DP_CYC) ? PU_CYC : DP_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > RDP_CYC) ? MAX_A : RDP_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  pwr_state_e state_q, state_d;
  logic [NUM_CMD-1:0] cmd_vec, arm_en, go;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic               tmr_zero;

  assign cmd_vec[CMD_SLEEP] = sleep_cmd_i;
  assign cmd_vec[CMD_WAKE]  = wake_cmd_i;
  assign arm_en[CMD_SLEEP]  = (state_q == ST_ACTIVE);
  assign arm_en[CMD_WAKE]   = (state_q == ST_ENTER) || (state_q == ST_SLEEP);

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_arm
    pwr_cmd_arm u_arm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arm_en_i  (arm_en[g]),
      .cmd_i     (cmd_vec[g]),
      .cs_rise_i (cs_rise_i),
      .go_o      (go[g])
    );
  end

  pwr_delay_timer #(
    .CNT_W    (CNT_W),
    .INIT_VAL (PU_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_PWRUP:  if (tmr_zero) state_d = ST_ACTIVE;
      ST_ACTIVE: if (go[CMD_SLEEP]) begin
        state_d  = ST_ENTER;
        load     = 1'b1;
        load_val = CNT_W'(DP_CYC - 1);
      end
      ST_ENTER, ST_SLEEP: begin
        // wake wins over entry completion
        if (go[CMD_WAKE]) begin
          state_d  = ST_EXIT;
          load     = 1'b1;
          load_val = CNT_W'(RDP_CYC - 1);
        end else if (state_q == ST_ENTER && tmr_zero) begin
          state_d = ST_SLEEP;
        end
      end
      ST_EXIT:   if (tmr_zero) state_d = ST_ACTIVE;
      default:   state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWRUP;
    else         state_q <= state_d;
  end

  pwr_viol_trap u_trap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .window_i (state_q == ST_EXIT),
    .cs_low_i (cs_low_i),
    .viol_o   (cs_viol_o)
  );

  assign access_ok_o = (state_q == ST_ACTIVE);
  assign reg_en_o    = (state_q != ST_ENTER) && (state_q != ST_SLEEP);
  assign asleep_o    = (state_q == ST_SLEEP);
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_rise_i,
  input logic cs_low_i,
  input logic access_ok_o,
  input logic reg_en_o,
  input logic asleep_o,
  input logic cs_viol_o
);
  // R3
  no_access_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_o |-> !access_ok_o);

  // R3
  access_drop_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(access_ok_o) |-> $past(cs_rise_i));

  // R4
  asleep_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> !reg_en_o);

  // R5
  regen_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_en_o) |-> $past(cs_rise_i) && !access_ok_o);

  // R8
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_viol_o |=> cs_viol_o);

  // R9
  viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_viol_o) |-> $past(cs_low_i) && $past(reg_en_o) && $past(!access_ok_o));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_rise_i   (cs_rise_i),
  .cs_low_i    (cs_low_i),
  .access_ok_o (access_ok_o),
  .reg_en_o    (reg_en_o),
  .asleep_o    (asleep_o),
  .cs_viol_o   (cs_viol_o)
);

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;
  localparam int unsigned PU  = 40;
  localparam int unsigned DP  = 5;
  localparam int unsigned RDP = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_cmd = 1'b0, wake_cmd = 1'b0, cs_rise = 1'b0, cs_low = 1'b0;
  logic access_ok, reg_en, asleep, cs_viol;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_sleep_ctrl #(.PU_CYC(PU), .DP_CYC(DP), .RDP_CYC(RDP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_cmd_i(sleep_cmd), .wake_cmd_i(wake_cmd),
    .cs_rise_i(cs_rise), .cs_low_i(cs_low), .access_ok_o(access_ok),
    .reg_en_o(reg_en), .asleep_o(asleep), .cs_viol_o(cs_viol)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic a, input logic r, input logic s);
    chk({req, " access_ok"}, access_ok, a);
    chk({req, " reg_en"}, reg_en, r);
    chk({req, " asleep"}, asleep, s);
  endtask

  // strobe one cycle, then chip-select rise; returns half a cycle after the accepting edge
  task automatic send(input bit is_sleep);
    if (is_sleep) sleep_cmd = 1'b1; else wake_cmd = 1'b1;
    tick(1);
    sleep_cmd = 1'b0; wake_cmd = 1'b0; cs_rise = 1'b1;
    tick(1);
    cs_rise = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    chk_all("R1 in reset", 1'b0, 1'b1, 1'b0);
    chk("R1 viol in reset", cs_viol, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    do_reset();
    tick(2);
    send(1'b1);  // R7 sleep during lockout
    tick(PU - 1 - 4);
    chk("R2 lockout last edge", access_ok, 1'b0);
    tick(1);
    chk("R2 access after lockout", access_ok, 1'b1);
    chk("R7 lockout sleep ignored", reg_en, 1'b1);
  endtask

  task automatic t_enter();
    cs_rise = 1'b1; tick(1); cs_rise = 1'b0; tick(2);
    chk_all("R6 bare rise", 1'b1, 1'b1, 1'b0);
    send(1'b0); tick(2);
    chk_all("R7 wake in active", 1'b1, 1'b1, 1'b0);
    cs_low = 1'b1; sleep_cmd = 1'b1; tick(1); sleep_cmd = 1'b0; tick(4); cs_low = 1'b0;
    chk_all("R6 strobe without rise", 1'b1, 1'b1, 1'b0);
    chk("R9 cs low in active", cs_viol, 1'b0);
    cs_rise = 1'b1; tick(1); cs_rise = 1'b0;
    chk_all("R3 sleep accepted", 1'b0, 1'b0, 1'b0);
    tick(DP - 1);
    chk("R4 entry last edge", asleep, 1'b0);
    tick(1);
    chk_all("R4 asleep", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_sleep_wake();
    cs_low = 1'b1; tick(3); cs_low = 1'b0;
    send(1'b1); tick(2);
    chk_all("R7 sleep while asleep", 1'b0, 1'b0, 1'b1);
    chk("R9 cs low in sleep", cs_viol, 1'b0);
    send(1'b0);
    chk_all("R5 wake accepted", 1'b0, 1'b1, 1'b0);
    tick(RDP - 1);
    chk("R5 exit last edge", access_ok, 1'b0);
    tick(1);
    chk("R5 access after exit", access_ok, 1'b1);
    chk("R9 no viol clean exit", cs_viol, 1'b0);
  endtask

  task automatic t_abort();
    send(1'b1);
    tick(1);
    send(1'b0);  // accepted 3 edges into entry
    chk_all("R10 wake aborts entry", 1'b0, 1'b1, 1'b0);
    tick(RDP - 1);
    chk("R10 exit last edge", access_ok, 1'b0);
    chk("R10 never asleep", asleep, 1'b0);
    tick(1);
    chk("R10 access after exit", access_ok, 1'b1);
  endtask

  task automatic t_violation();
    send(1'b1);
    tick(DP + 1);
    chk("R4 asleep before wake", asleep, 1'b1);
    send(1'b0);
    tick(4);
    cs_low = 1'b1; tick(1); cs_low = 1'b0;
    chk("R8 viol set", cs_viol, 1'b1);
    chk("R8 access still blocked", access_ok, 1'b0);
    tick(RDP - 1 - 5);
    chk("R8 exit last edge", access_ok, 1'b0);
    tick(1);
    chk("R8 exit completes", access_ok, 1'b1);
    tick(10);
    chk("R8 viol sticky", cs_viol, 1'b1);
    do_reset();
    tick(1);
    chk("R1 viol cleared", cs_viol, 1'b0);
  endtask

  initial begin
    t_powerup();
    t_enter();
    t_sleep_wake();
    t_abort();
    t_violation();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule